// File: doc/BRIEF.md
# Interprocessor and Interval Interrupt Control Register

This block holds the pending interprocessor interrupt (IPI) and interval-timer interrupt state for a small group of processors, up to four. Software changes the state by writing one 64-bit word that holds three per-processor bit fields. One field requests IPIs, one clears IPIs and one clears interval interrupts. A periodic tick input from an external timer posts an interval interrupt to every present processor. Each processor has one IPI output line and one interval output line, and each line follows its pending bit directly.

A write also reports misuse through flags that pulse for one cycle. One flag marks an IPI request to a processor that already has an IPI pending. One marks an IPI clear to a processor that has none. One marks a field that is nonzero but names no present processor. A read is combinational. It returns both pending vectors and the identifier of the processor doing the read. A parameter sets how many processors are present, and bits for absent processors are ignored.

Top module: `xcpu_irq_reg`

## Requirements
- R1: After reset every pending bit, every output line and every flag is 0.
- R2: A write sets the IPI pending bit, visible on `ipi_irq` the next cycle, of each present processor p whose bit 12+p is set. A processor that already has an IPI pending keeps it pending.
- R3: A write clears the IPI pending bit of each present processor p whose bit 8+p is set. When one write both requests and clears an IPI for the same processor, the clear is applied last and the bit ends at 0.
- R4: A write clears the interval pending bit of each present processor p whose bit 4+p is set.
- R5: A cycle with `tick` high sets the interval pending bit of every present processor. If a clear for the same processor arrives in that cycle, the tick wins and the bit stays set.
- R6: `warn_dup_ipi` is 1 for the one cycle after a write that requests an IPI for a present processor whose IPI was already pending. Otherwise it is 0.
- R7: `warn_clr_idle` is 1 for the one cycle after a write that clears the IPI of a present processor whose IPI was not pending. Otherwise it is 0.
- R8: `err_no_target` is 1 for the one cycle after a write in which any of the three fields (15:12, 11:8, 7:4) is nonzero but selects no present processor.
- R9: `rd_data` holds `rd_cpu_id` in bits 1:0, the interval pending bits in bits 7:4 and the IPI pending bits in bits 11:8. All other bits are 0.
- R10: Field bits and output lines of absent processors (index NCPU and above) are ignored and stay 0.
- R11: In a cycle with neither a write nor a tick, both pending vectors keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 64 | Write word holding the request and clear fields |
| tick | input | 1 | Interval tick, one cycle per period |
| rd_cpu_id | input | 2 | Identifier of the processor that is reading |
| rd_data | output | 64 | Read word: pending state and reader identifier |
| ipi_irq | output | 4 | IPI line for each processor |
| iti_irq | output | 4 | Interval interrupt line for each processor |
| warn_dup_ipi | output | 1 | Pulse: IPI requested while already pending |
| warn_clr_idle | output | 1 | Pulse: IPI cleared while not pending |
| err_no_target | output | 1 | Pulse: nonzero field with no present target |

## Verification
The properties assume that `wr_en` and `tick` are sampled once per clock edge and that all write fields are known whenever `wr_en` is high. The stimulus keeps to this by changing inputs only just after a rising edge and by always driving the whole write word. The properties also assume that a read identifier is always driven. The bench sets it to a defined value before every read check. The sweeps run with three processors present, so that one absent bit in each field is always exercised.

// File: rtl/xcpu_irq_pkg.sv
package xcpu_irq_pkg;
    localparam int CPU_MAX    = 4;
    localparam int ID_W       = 2;
    localparam int DATA_W     = 64;
    localparam int ITI_CLR_LO = 4;
    localparam int IPI_CLR_LO = 8;
    localparam int IPI_REQ_LO = 12;

    typedef struct packed {
        logic [CPU_MAX-1:0] req;
        logic [CPU_MAX-1:0] clr_ipi;
        logic [CPU_MAX-1:0] clr_iti;
        logic               bad;
    } wr_fields_t;

    typedef struct packed {
        logic [CPU_MAX-1:0] ipi;
        logic [CPU_MAX-1:0] iti;
        logic               dup;
        logic               idle;
        logic               err;
    } irq_state_t;
endpackage

// File: rtl/xcpu_wr_decode.sv
module xcpu_wr_decode
    import xcpu_irq_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output wr_fields_t        fields
);
    localparam logic [CPU_MAX-1:0] PRESENT = CPU_MAX'((1 << NCPU) - 1);

    logic [CPU_MAX-1:0] raw_req, raw_ci, raw_ct;

    always_comb begin
        raw_req = wr_data[IPI_REQ_LO +: CPU_MAX];
        raw_ci  = wr_data[IPI_CLR_LO +: CPU_MAX];
        raw_ct  = wr_data[ITI_CLR_LO +: CPU_MAX];
        fields.req     = wr_en ? (raw_req & PRESENT) : '0;
        fields.clr_ipi = wr_en ? (raw_ci  & PRESENT) : '0;
        fields.clr_iti = wr_en ? (raw_ct  & PRESENT) : '0;
        fields.bad     = wr_en &&
                         (((raw_req != '0) && ((raw_req & PRESENT) == '0)) ||
                          ((raw_ci  != '0) && ((raw_ci  & PRESENT) == '0)) ||
                          ((raw_ct  != '0) && ((raw_ct  & PRESENT) == '0)));
    end
endmodule

// File: rtl/xcpu_irq_next.sv
module xcpu_irq_next
    import xcpu_irq_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  irq_state_t state_q,
    input  wr_fields_t fields,
    input  logic       tick,
    output irq_state_t state_d
);
    logic [CPU_MAX-1:0] ipi_n, iti_n, dup_v, idle_v;

    for (genvar p = 0; p < CPU_MAX; p++) begin : g_cpu
        if (p < NCPU) begin : g_present
            always_comb begin
                ipi_n[p]  = (state_q.ipi[p] | fields.req[p]) & ~fields.clr_ipi[p];
                iti_n[p]  = tick | (state_q.iti[p] & ~fields.clr_iti[p]);
                dup_v[p]  = fields.req[p] & state_q.ipi[p];
                idle_v[p] = fields.clr_ipi[p] & ~state_q.ipi[p];
            end
        end else begin : g_absent
            always_comb begin
                ipi_n[p]  = 1'b0;
                iti_n[p]  = 1'b0;
                dup_v[p]  = 1'b0;
                idle_v[p] = 1'b0;
            end
        end
    end

    always_comb begin
        state_d      = '0;
        state_d.ipi  = ipi_n;
        state_d.iti  = iti_n;
        state_d.dup  = |dup_v;
        state_d.idle = |idle_v;
        state_d.err  = fields.bad;
    end
endmodule

// File: rtl/xcpu_rd_mux.sv
module xcpu_rd_mux
    import xcpu_irq_pkg::*;
(
    input  logic [ID_W-1:0]    rd_cpu_id,
    input  logic [CPU_MAX-1:0] ipi,
    input  logic [CPU_MAX-1:0] iti,
    output logic [DATA_W-1:0]  rd_data
);
    always_comb begin
        rd_data                           = '0;
        rd_data[ID_W-1:0]                 = rd_cpu_id;
        rd_data[ITI_CLR_LO +: CPU_MAX]    = iti;
        rd_data[IPI_CLR_LO +: CPU_MAX]    = ipi;
    end
endmodule

// File: rtl/xcpu_irq_reg.sv
module xcpu_irq_reg
    import xcpu_irq_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [63:0]       wr_data,
    input  logic              tick,
    input  logic [1:0]        rd_cpu_id,
    output logic [63:0]       rd_data,
    output logic [3:0]        ipi_irq,
    output logic [3:0]        iti_irq,
    output logic              warn_dup_ipi,
    output logic              warn_clr_idle,
    output logic              err_no_target
);
    wr_fields_t fields;
    irq_state_t state_d, state_q;

    xcpu_wr_decode #(.NCPU(NCPU)) u_dec (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .fields  (fields)
    );

    xcpu_irq_next #(.NCPU(NCPU)) u_next (
        .state_q (state_q),
        .fields  (fields),
        .tick    (tick),
        .state_d (state_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    xcpu_rd_mux u_rd (
        .rd_cpu_id (rd_cpu_id),
        .ipi       (state_q.ipi),
        .iti       (state_q.iti),
        .rd_data   (rd_data)
    );

    assign ipi_irq       = state_q.ipi;
    assign iti_irq       = state_q.iti;
    assign warn_dup_ipi  = state_q.dup;
    assign warn_clr_idle = state_q.idle;
    assign err_no_target = state_q.err;
endmodule

// File: rtl/xcpu_irq_chk.sv
module xcpu_irq_chk #(
    parameter int NCPU = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [63:0] wr_data,
    input logic        tick,
    input logic [1:0]  rd_cpu_id,
    input logic [63:0] rd_data,
    input logic [3:0]  ipi_irq,
    input logic [3:0]  iti_irq,
    input logic        warn_dup_ipi,
    input logic        warn_clr_idle,
    input logic        err_no_target
);
    localparam logic [3:0] PM = 4'((1 << NCPU) - 1);

    logic [3:0] req_only, clr_sel, req_sel;
    assign req_sel  = wr_data[15:12] & PM;
    assign clr_sel  = wr_data[11:8] & PM;
    assign req_only = req_sel & ~clr_sel;

    // R10
    absent_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ipi_irq & ~PM) == 4'd0) && ((iti_irq & ~PM) == 4'd0));

    // R5
    tick_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (iti_irq == PM));

    // R2
    ipi_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((ipi_irq & $past(req_only)) == $past(req_only)));

    // R3
    ipi_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((ipi_irq & $past(clr_sel)) == 4'd0));

    // R6
    dup_warn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ((req_sel & ipi_irq) != 4'd0)) |=> warn_dup_ipi);

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !tick) |=> ($stable(ipi_irq) && $stable(iti_irq)));

    // R8
    no_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !err_no_target);

    // R9
    rd_layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[1:0] == rd_cpu_id) && (rd_data[11:8] == ipi_irq) &&
        (rd_data[7:4] == iti_irq));
endmodule

bind xcpu_irq_reg xcpu_irq_chk #(.NCPU(NCPU)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .tick          (tick),
    .rd_cpu_id     (rd_cpu_id),
    .rd_data       (rd_data),
    .ipi_irq       (ipi_irq),
    .iti_irq       (iti_irq),
    .warn_dup_ipi  (warn_dup_ipi),
    .warn_clr_idle (warn_clr_idle),
    .err_no_target (err_no_target)
);

// File: tb/test_xcpu_irq_reg.sv
`timescale 1ns/1ps
module test_xcpu_irq_reg;
    localparam int NCPU = 3;
    localparam logic [3:0] PM = 4'((1 << NCPU) - 1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic        tick = 1'b0;
    logic [1:0]  rd_cpu_id = '0;
    logic [63:0] rd_data;
    logic [3:0]  ipi_irq, iti_irq;
    logic        warn_dup_ipi, warn_clr_idle, err_no_target;

    int n_run = 0;
    int n_fail = 0;
    logic [3:0] mi = '0;
    logic [3:0] mt = '0;

    always #2 clk = ~clk;

    xcpu_irq_reg #(.NCPU(NCPU)) i_xcpu_irq_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .tick(tick), .rd_cpu_id(rd_cpu_id), .rd_data(rd_data),
        .ipi_irq(ipi_irq), .iti_irq(iti_irq), .warn_dup_ipi(warn_dup_ipi),
        .warn_clr_idle(warn_clr_idle), .err_no_target(err_no_target)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle of stimulus; the model is updated from the requirements.
    task automatic op(input logic w, input logic [63:0] d, input logic t, input string tag);
        logic [3:0] rq, ci, ct;
        logic e_dup, e_idle, e_err;
        rq = w ? d[15:12] & PM : 4'd0;
        ci = w ? d[11:8]  & PM : 4'd0;
        ct = w ? d[7:4]   & PM : 4'd0;
        e_dup  = |(rq & mi);
        e_idle = |(ci & ~mi);
        e_err  = w && ((d[15:12] != 0 && rq == 0) || (d[11:8] != 0 && ci == 0) ||
                       (d[7:4] != 0 && ct == 0));
        mi = (mi | rq) & ~ci;
        mt = (mt & ~ct) | (t ? PM : 4'd0);
        wr_en = w; wr_data = d; tick = t;
        @(posedge clk); #1;
        wr_en = 1'b0; tick = 1'b0; wr_data = '0;
        check(tag, {49'd0, ipi_irq, iti_irq, warn_dup_ipi, warn_clr_idle, err_no_target},
                   {49'd0, mi, mt, e_dup, e_idle, e_err});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        rd_cpu_id = 2'd2;
        #1;
        // R1: reset state
        check("R1", {ipi_irq, iti_irq, warn_dup_ipi, warn_clr_idle, err_no_target}, 11'd0);
        check("R1 R9 read", rd_data, 64'd2);

        // R2 R3 R6 R7 R8 R10: every reachable IPI state against every request/clear pair
        for (int s = 0; s < 8; s++) begin
            for (int rq = 0; rq < 16; rq++) begin
                for (int cl = 0; cl < 16; cl++) begin
                    op(1'b1, 64'hF00, 1'b0, "R3 setup");
                    op(1'b1, 64'(s) << 12, 1'b0, "R2 setup");
                    op(1'b1, (64'(rq) << 12) | (64'(cl) << 8), 1'b0, "R2 R3 R6 R7 R8 R10 sweep");
                end
            end
        end

        // R4 R5 R8 R10: every interval state against every clear, with and without tick
        for (int s = 0; s < 8; s++) begin
            for (int cl = 0; cl < 16; cl++) begin
                for (int t = 0; t < 2; t++) begin
                    op(1'b0, 64'd0, 1'b1, "R5 tick");
                    op(1'b1, 64'(~s & 7) << 4, 1'b0, "R4 setup");
                    op(1'b1, 64'(cl) << 4, t[0], "R4 R5 sweep");
                end
            end
        end

        // R11: idle cycles keep state
        op(1'b1, 64'h5000, 1'b0, "R2");
        for (int k = 0; k < 4; k++) op(1'b0, 64'd0, 1'b0, "R11 hold");

        // R9: read layout for every identifier and several states
        for (int s = 0; s < 8; s++) begin
            op(1'b1, 64'hF00 | (64'(s) << 12), 1'b0, "R9 setup");
            op(1'b1, 64'(s) << 4, 1'b0, "R9 setup");
            for (int id = 0; id < 4; id++) begin
                rd_cpu_id = id[1:0];
                #1;
                check("R9", rd_data, (64'(mi) << 8) | (64'(mt) << 4) | 64'(id));
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule